// File: doc/BRIEF.md
# Half-Step Prescaled Baud Tick Generator

This block derives the oversampling tick of a serial receiver/transmitter from one input clock. Two dividers run in series, both on that clock. The first is a prescaler. Its factor comes from a 5-bit select code and moves in half steps: the factor equals (code+1)/2, so the factors are 1, 1.5, 2, 2.5 and onward up to 16. The second stage is an integer divisor N. The result is a one-cycle enable pulse, `tick_o`, that fires once per prescale×N input clocks. Sixteen of these ticks make one bit time. A select code of zero stops the clock completely.

Each parameter is loaded from its own write port. A write to either port restarts both counters. After a restart, the first tick comes one full period later, so a tick is never cut short or doubled. For a half-step factor, the prescaler alternates between the two nearest integer counts, starting with the shorter one. This keeps the average period exact over every pair of prescaler periods. `running_o` shows whether the loaded select code lets the clock run.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the select code is 0 and the divisor is 0. `tick_o` and `running_o` are both low.
- R2: While the loaded select code is 0, `tick_o` never goes high and `running_o` is low.
- R3: For an odd select code c, every tick interval after the first is exactly ((c+1)/2)·N input clock cycles.
- R4: For an even nonzero select code c, the prescaler periods alternate between c/2 and c/2+1 cycles, with the shorter period first after a restart. Tick times follow from that sequence, so any two consecutive intervals sum to (c+1)·N when N is odd.
- R5: A divisor value of 0 gives the same tick times as a divisor of 1.
- R6: A write to either port, sampled on clock edge E, restarts the counters. `tick_o` is low in the cycle that starts at E. The first tick is high in the cycle that starts exactly one full period of edges after E.
- R7: Writing only the select port keeps the previously loaded divisor, and writing only the divisor port keeps the previously loaded select code.
- R8: `running_o` becomes (written code ≠ 0) in the cycle after a select write and holds until the next select write. `tick_o` is high only while `running_o` is high.
- R9: Each tick is one cycle wide whenever the period exceeds one cycle. With a factor of 1 and N = 1, a tick is produced in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that times both stages |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Load strobe for the select code |
| sel_i | input | 5 | Prescaler select code; 0 stops the clock |
| div_we_i | input | 1 | Load strobe for the divisor |
| div_i | input | 11 | Integer divisor N (0 acts as 1) |
| tick_o | output | 1 | One-cycle oversampling enable pulse |
| running_o | output | 1 | High while the select code is nonzero |

## Verification
The reference point for every result is the clock edge that samples a write. `running_o` is due one cycle after that edge. The k-th tick is due in the cycle that starts a number of edges after it equal to the running sum of prescaler periods, counted in groups of N. The bench drives each write on a falling edge. It then counts rising edges from the one that samples the write and looks at `tick_o` on every falling edge. It compares the index of each tick it sees against a list of due indices, computed from the factor sequence that the requirements define, and also checks that no extra ticks appear.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SEL_W = 5,
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             running_o
);
  localparam int PC_W = SEL_W + 1;

  logic [SEL_W-1:0] code_q;
  logic [DIV_W-1:0] div_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [DIV_W-1:0] dcnt_q;
  logic             phase_q, tick_q;

  logic [PC_W-1:0]  base, plen;
  logic [DIV_W-1:0] dlim;
  logic             half, pend, dend, restart;

  assign base    = PC_W'(({1'b0, code_q} + PC_W'(1)) >> 1);
  assign half    = (code_q != '0) && !code_q[0];
  assign plen    = base + PC_W'(half && phase_q);
  assign pend    = pcnt_q == plen - PC_W'(1);
  assign dlim    = (div_q == '0) ? DIV_W'(1) : div_q;
  assign dend    = dcnt_q == dlim - DIV_W'(1);
  assign restart = sel_we_i || div_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      div_q   <= '0;
      pcnt_q  <= '0;
      dcnt_q  <= '0;
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else if (restart) begin
      if (sel_we_i) code_q <= sel_i;
      if (div_we_i) div_q  <= div_i;
      pcnt_q  <= '0;
      dcnt_q  <= '0;
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else if (code_q != '0) begin
      pcnt_q <= pend ? '0 : pcnt_q + PC_W'(1);
      if (pend) begin
        phase_q <= half && !phase_q;
        dcnt_q  <= dend ? '0 : dcnt_q + DIV_W'(1);
      end
      tick_q <= pend && dend;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o    = tick_q;
  assign running_o = code_q != '0;
endmodule

module baud_tick_gen_chk #(
  parameter int SEL_W = 5,
  parameter int DIV_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_we_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             div_we_i,
  input logic             tick_o,
  input logic             running_o
);
  // R2
  no_tick_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> running_o);
  // R6
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i || div_we_i) |=> !tick_o);
  // R8
  running_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> (running_o == ($past(sel_i) != '0)));
  // R8
  running_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(running_o));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_we_i(sel_we_i), .sel_i(sel_i),
  .div_we_i(div_we_i), .tick_o(tick_o), .running_o(running_o));

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0, div_we = 1'b0;
  logic [4:0]  sel = '0;
  logic [10:0] div = '0;
  logic        tick, running;
  int checks = 0, errors = 0;
  int cur_code = 0, cur_n = 0;

  always #4 clk = ~clk;

  baud_tick_gen dut_i (.clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_i(sel),
                       .div_we_i(div_we), .div_i(div), .tick_o(tick), .running_o(running));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives on negedge; the write is sampled on the next posedge, which the task waits for
  task automatic do_write(input bit ws, input int s, input bit wd, input int d);
    @(negedge clk);
    sel_we = ws; sel = 5'(s); div_we = wd; div = 11'(d);
    if (ws) cur_code = s;
    if (wd) cur_n = d;
    @(posedge clk);
    @(negedge clk);
    sel_we = 1'b0; div_we = 1'b0;
  endtask

  // observes cycles 1..horizon after the write edge and checks tick indices
  task automatic expect_ticks(input int nt, input int extra, input string req);
    int exp_t[16];
    int t = 0, ph = 0, cnt = 0, g = 0, seen = 0;
    int base = (cur_code + 1) / 2;
    bit hf = (cur_code != 0) && (cur_code % 2 == 0);
    int nn = (cur_n == 0) ? 1 : cur_n;
    while (g < nt) begin
      t += base + ((hf && ph == 1) ? 1 : 0);
      if (hf) ph ^= 1;
      cnt++;
      if (cnt == nn) begin exp_t[g] = t; g++; cnt = 0; end
    end
    chk(tick == 1'b0, {req, " quiet after write (R6)"}, int'(tick), 0);
    for (int k = 1; k <= ((nt > 0) ? exp_t[nt-1] : 0) + extra; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick) begin
        if (seen < nt) chk(k == exp_t[seen], req, k, exp_t[seen]);
        else chk(1'b0, {req, " extra tick"}, k, -1);
        seen++;
      end
    end
    chk(seen == nt, {req, " tick count"}, seen, nt);
  endtask

  task automatic t_reset;
    chk(tick == 1'b0 && running == 1'b0, "R1 reset outputs", {tick, running}, 0);
  endtask

  task automatic t_stopped;
    do_write(1, 0, 1, 5);
    chk(running == 1'b0, "R2 running low", running, 0);
    expect_ticks(0, 200, "R2 stopped");
  endtask

  task automatic t_integer;
    do_write(1, 1, 1, 1);
    chk(running == 1'b1, "R8 running high", running, 1);
    expect_ticks(8, 0, "R9 factor1 N1");
    do_write(1, 7, 1, 3);
    expect_ticks(4, 0, "R3 factor4 N3");
    do_write(1, 31, 1, 2);
    expect_ticks(3, 0, "R3 factor16 N2");
  endtask

  task automatic t_half;
    do_write(1, 2, 1, 1);
    expect_ticks(6, 0, "R4 factor1.5 N1");
    do_write(1, 4, 1, 3);
    expect_ticks(4, 0, "R4 factor2.5 N3");
  endtask

  task automatic t_zero_div;
    do_write(1, 3, 1, 0);
    expect_ticks(5, 0, "R5 N0 as N1");
  endtask

  task automatic t_restart;
    do_write(1, 5, 1, 4);
    repeat (5) @(negedge clk);
    do_write(0, 0, 1, 2);
    expect_ticks(3, 0, "R6 R7 div-only restart");
    repeat (3) @(negedge clk);
    do_write(1, 1, 0, 0);
    chk(running == 1'b1, "R8 running after sel write", running, 1);
    expect_ticks(3, 0, "R7 sel-only keeps N2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_stopped();
    t_integer();
    t_half();
    t_zero_div();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule